// File: doc/BRIEF.md
# Hardware-Monitor Control Register

This block holds the master control byte of a system hardware monitor, together with the small group of companion registers that its initialise command resets: two interrupt status bytes, two interrupt mask bytes, an output-mode byte and a sensor-configuration byte. A host reaches all of them over a plain single-cycle write strobe with an address and a combinational read port. The measurement path, limit comparison and serial bus framing are outside the block. Limit-violation events arrive as a vector of strobes, and chassis-intrusion events arrive as a single level.

Several control bits act over time. One bit requests a millisecond-scale active-low pulse on the reset/OS output, and it reads back as 1 until the pulse ends. A second bit clears the intrusion latch and then clears itself. A third bit is a one-shot initialise command that returns the whole group to its defaults. A suppress bit silences both output pins and freezes status latching, and it leaves the latched status intact. The interrupt pin can be modelled as an active-low open-drain pin or as an active-high source-only pin, using a separate drive value and output enable.

Top module: `hwmon_ctrl_reg`

## Requirements
- R1: After reset the control byte (address 0) reads 8'h08 and every other register reads 0. The address map is: 0 control, 1-2 status, 3-4 mask, 5 output mode, 6 sensor configuration, 7 reads 0. The control bit positions are: 0 start, 1 interrupt enable, 2 polarity, 3 suppress, 4 reset-pulse request, 5 intrusion clear, 6 general output, 7 initialise.
- R2: While monitoring runs, each event strobe sets its status bit. Writing 1 to a status bit clears it. The interrupt is active when interrupt enable is 1, suppress is 0 and at least one status bit has its mask bit at 0.
- R3: `mon_run_o` is high exactly when start is 1 and suppress is 0. While it is low, event strobes leave the status registers unchanged.
- R4: While the interrupt is active, `int_oe_o` is 1, and `int_do_o` equals the polarity bit: 0 gives an active-low open-drain pin and 1 gives an active-high source-only pin. While the interrupt is inactive, `int_oe_o` is 0.
- R5: Writing 0 to start does not deassert an interrupt that is already active.
- R6: While suppress is 1, `int_oe_o` is 0, `rst_os_n_o` is 1 and monitoring stops. The status contents are kept. Clearing suppress restores both pins.
- R7: Writing 1 to bit 4 while output-mode bits [7:6] equal 2'b10 drives `rst_os_n_o` low for ceil(CLK_HZ*PULSE_MS/1000) cycles, starting the cycle after the write. Bit 4 reads 1 for the length of the pulse and then reads 0. In any other mode the write is ignored.
- R8: A pulse request made while a pulse is running does not extend the pulse.
- R9: `gpo_o` follows control bit 6.
- R10: Writing 1 to bit 5 makes bit 5 read 1 for one cycle. On the following edge `ci_latched_o` clears and bit 5 returns to 0.
- R11: A control write with bit 7 set makes bit 7 read 1 for one cycle, and ignores every other bit in that write. On the next edge the control, status, mask, output-mode and sensor-configuration registers return to their reset values. The intrusion latch is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for addr_i |
| evt_i | input | 16 | Limit-event strobes, one per status bit |
| ci_i | input | 1 | Chassis-intrusion detection level |
| mon_run_o | output | 1 | Monitoring active |
| int_oe_o | output | 1 | Interrupt pin output enable |
| int_do_o | output | 1 | Interrupt pin drive value when enabled |
| rst_os_n_o | output | 1 | Reset/OS output, active low |
| gpo_o | output | 1 | General purpose output |
| ci_latched_o | output | 1 | Intrusion latch state |

## Verification
The interrupt path is tried with status set or clear, the mask on or off, enable on or off, start dropped and suppress raised. These cases separate the gating by enable, by mask and by suppress, and show that start only gates latching. The pulse is requested in the wrong mode, in the right mode, again during a running pulse, and while suppress is raised mid-pulse. Its measured length distinguishes a pulse that is restarted from one that is ignored, and distinguishes a pulse that is cut short from one that is only hidden. Initialise is issued together with a pulse request and other set bits, which shows both its priority and its one-cycle delay.

// File: rtl/hwmon_ctrl_pkg.sv
package hwmon_ctrl_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int NUM_STS = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STS0 = 3'd1;
  localparam logic [ADDR_W-1:0] A_MSK0 = 3'd3;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd5;
  localparam logic [ADDR_W-1:0] A_SCFG = 3'd6;

  localparam int B_START  = 0;
  localparam int B_INTEN  = 1;
  localparam int B_POL    = 2;
  localparam int B_SUPP   = 3;
  localparam int B_PULSE  = 4;
  localparam int B_CICLR  = 5;
  localparam int B_GPO    = 6;
  localparam int B_INIT   = 7;

  localparam logic [DATA_W-1:0] CTRL_RESET = 8'h08;

  // cycles needed for at least ms milliseconds at clk_hz
  function automatic int unsigned pulse_cycles(int unsigned clk_hz, int unsigned ms);
    longint unsigned prod;
    prod = longint'(clk_hz) * longint'(ms);
    return int'((prod + 64'd999) / 64'd1000);
  endfunction

  // output-mode byte selects reset mode when [7:6] == 2'b10
  function automatic logic mode_is_reset(logic [DATA_W-1:0] mode);
    return mode[7] & ~mode[6];
  endfunction

  function automatic logic irq_hit(logic [NUM_STS*DATA_W-1:0] sts,
                                   logic [NUM_STS*DATA_W-1:0] msk);
    return |(sts & ~msk);
  endfunction
endpackage

// File: rtl/hwmon_pulse_timer.sv
module hwmon_pulse_timer #(
  parameter int unsigned CYC   = 1000,
  parameter int          CNT_W = $clog2(CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic req_i,
  output logic active_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end else if (req_i) begin
      act_q <= 1'b1;
      cnt_q <= CNT_W'(CYC - 1);
    end
  end

  assign active_o = act_q;
  assign done_o   = act_q && (cnt_q == '0);
endmodule

// File: rtl/hwmon_intrusion_latch.sv
module hwmon_intrusion_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic ci_i,
  input  logic clr_req_i,
  output logic latched_o,
  output logic clr_pend_o
);
  logic lat_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (init_i || pend_q) begin
      pend_q <= 1'b0;
    end else if (clr_req_i) begin
      pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lat_q <= 1'b0;
    else if (pend_q)  lat_q <= 1'b0;
    else if (ci_i)    lat_q <= 1'b1;
  end

  assign latched_o  = lat_q;
  assign clr_pend_o = pend_q;
endmodule

// File: rtl/hwmon_irq_bank.sv
module hwmon_irq_bank
  import hwmon_ctrl_pkg::*;
#(
  parameter int N = NUM_STS,
  localparam int W = N * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              run_i,
  input  logic [W-1:0]      evt_i,
  input  logic [N-1:0]      wr_sts_i,
  input  logic [N-1:0]      wr_msk_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [W-1:0]      sts_o,
  output logic [W-1:0]      msk_o
);
  for (genvar g = 0; g < N; g++) begin : g_byte
    logic [DATA_W-1:0] sts_q, msk_q, sts_nxt, evt_b;

    assign evt_b = evt_i[g*DATA_W +: DATA_W];

    always_comb begin
      sts_nxt = sts_q;
      if (wr_sts_i[g]) sts_nxt = sts_nxt & ~wdata_i;
      if (run_i)       sts_nxt = sts_nxt | evt_b;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sts_q <= '0;
        msk_q <= '0;
      end else if (init_i) begin
        sts_q <= '0;
        msk_q <= '0;
      end else begin
        sts_q <= sts_nxt;
        if (wr_msk_i[g]) msk_q <= wdata_i;
      end
    end

    assign sts_o[g*DATA_W +: DATA_W] = sts_q;
    assign msk_o[g*DATA_W +: DATA_W] = msk_q;
  end
endmodule

// File: rtl/hwmon_ctrl_reg.sv
module hwmon_ctrl_reg
  import hwmon_ctrl_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 250_000_000,
  parameter int unsigned PULSE_MS = 10
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rd_data_o,
  input  logic [NUM_STS*DATA_W-1:0] evt_i,
  input  logic                      ci_i,
  output logic                      mon_run_o,
  output logic                      int_oe_o,
  output logic                      int_do_o,
  output logic                      rst_os_n_o,
  output logic                      gpo_o,
  output logic                      ci_latched_o
);
  localparam int unsigned PULSE_CYC = pulse_cycles(CLK_HZ, PULSE_MS);
  localparam int          CNT_W     = $clog2(PULSE_CYC + 1);
  localparam int          SW        = NUM_STS * DATA_W;

  logic start_q, inten_q, pol_q, supp_q, gpo_q, init_pend_q;
  logic [DATA_W-1:0] mode_q, scfg_q;

  // named events
  logic wr_ok, wr_ctrl, init_req, pulse_req, ci_clr_req;
  logic mode_rst, pulse_act, pulse_done, ci_pend, int_active;
  logic [NUM_STS-1:0] wr_sts, wr_msk;
  logic [SW-1:0] sts, msk;
  logic [DATA_W-1:0] ctrl_rd;

  assign wr_ok      = wr_en_i && !init_pend_q;
  assign wr_ctrl    = wr_ok && (addr_i == A_CTRL);
  assign init_req   = wr_ctrl && wdata_i[B_INIT];
  assign mode_rst   = mode_is_reset(mode_q);
  assign pulse_req  = wr_ctrl && !wdata_i[B_INIT] && wdata_i[B_PULSE] && mode_rst;
  assign ci_clr_req = wr_ctrl && !wdata_i[B_INIT] && wdata_i[B_CICLR];

  always_comb begin
    for (int i = 0; i < NUM_STS; i++) begin
      wr_sts[i] = wr_ok && (addr_i == A_STS0 + ADDR_W'(i));
      wr_msk[i] = wr_ok && (addr_i == A_MSK0 + ADDR_W'(i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= CTRL_RESET[B_START];
      inten_q <= CTRL_RESET[B_INTEN];
      pol_q   <= CTRL_RESET[B_POL];
      supp_q  <= CTRL_RESET[B_SUPP];
      gpo_q   <= CTRL_RESET[B_GPO];
    end else if (init_pend_q) begin
      start_q <= CTRL_RESET[B_START];
      inten_q <= CTRL_RESET[B_INTEN];
      pol_q   <= CTRL_RESET[B_POL];
      supp_q  <= CTRL_RESET[B_SUPP];
      gpo_q   <= CTRL_RESET[B_GPO];
    end else if (wr_ctrl && !wdata_i[B_INIT]) begin
      start_q <= wdata_i[B_START];
      inten_q <= wdata_i[B_INTEN];
      pol_q   <= wdata_i[B_POL];
      supp_q  <= wdata_i[B_SUPP];
      gpo_q   <= wdata_i[B_GPO];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_pend_q <= 1'b0;
      mode_q      <= '0;
      scfg_q      <= '0;
    end else begin
      init_pend_q <= init_req;
      if (init_pend_q) begin
        mode_q <= '0;
        scfg_q <= '0;
      end else begin
        if (wr_ok && addr_i == A_MODE) mode_q <= wdata_i;
        if (wr_ok && addr_i == A_SCFG) scfg_q <= wdata_i;
      end
    end
  end

  hwmon_pulse_timer #(.CYC(PULSE_CYC), .CNT_W(CNT_W)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (init_pend_q),
    .req_i    (pulse_req),
    .active_o (pulse_act),
    .done_o   (pulse_done)
  );

  hwmon_intrusion_latch u_ci (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (init_pend_q),
    .ci_i       (ci_i),
    .clr_req_i  (ci_clr_req),
    .latched_o  (ci_latched_o),
    .clr_pend_o (ci_pend)
  );

  hwmon_irq_bank #(.N(NUM_STS)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .init_i   (init_pend_q),
    .run_i    (mon_run_o),
    .evt_i    (evt_i),
    .wr_sts_i (wr_sts),
    .wr_msk_i (wr_msk),
    .wdata_i  (wdata_i),
    .sts_o    (sts),
    .msk_o    (msk)
  );

  assign mon_run_o  = start_q && !supp_q;
  assign int_active = inten_q && !supp_q && irq_hit(sts, msk);
  assign int_oe_o   = int_active;
  assign int_do_o   = pol_q;
  assign rst_os_n_o = !(pulse_act && !supp_q);
  assign gpo_o      = gpo_q;

  assign ctrl_rd = {init_pend_q, gpo_q, ci_pend, pulse_act,
                    supp_q, pol_q, inten_q, start_q};

  always_comb begin
    rd_data_o = '0;
    if (addr_i == A_CTRL) rd_data_o = ctrl_rd;
    if (addr_i == A_MODE) rd_data_o = mode_q;
    if (addr_i == A_SCFG) rd_data_o = scfg_q;
    for (int i = 0; i < NUM_STS; i++) begin
      if (addr_i == A_STS0 + ADDR_W'(i)) rd_data_o = sts[i*DATA_W +: DATA_W];
      if (addr_i == A_MSK0 + ADDR_W'(i)) rd_data_o = msk[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/hwmon_ctrl_chk.sv
module hwmon_ctrl_chk #(
  parameter int unsigned PULSE_CYC = 1000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       supp_q,
  input logic       inten_q,
  input logic       int_oe_o,
  input logic       rst_os_n_o,
  input logic       pulse_act,
  input logic       init_pend_q,
  input logic       mode_rst,
  input logic       ci_pend,
  input logic       ci_latched_o,
  input logic [7:0] ctrl_rd
);
  int unsigned run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_len <= 0;
    else if (pulse_act) run_len <= run_len + 1;
    else                run_len <= 0;
  end

  a_r6_suppress_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supp_q |-> (!int_oe_o && rst_os_n_o));

  a_r2_int_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inten_q |-> !int_oe_o);

  a_r7_pulse_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pulse_act) && !$past(init_pend_q)) |-> (run_len >= PULSE_CYC));

  a_r7_mode_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_act) |-> $past(mode_rst));

  a_r10_ci_selfclear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ci_pend |=> (!ci_pend && !ci_latched_o));

  a_r11_init_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_pend_q |=> (ctrl_rd == 8'h08));
endmodule

bind hwmon_ctrl_reg hwmon_ctrl_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .supp_q       (supp_q),
  .inten_q      (inten_q),
  .int_oe_o     (int_oe_o),
  .rst_os_n_o   (rst_os_n_o),
  .pulse_act    (pulse_act),
  .init_pend_q  (init_pend_q),
  .mode_rst     (mode_rst),
  .ci_pend      (ci_pend),
  .ci_latched_o (ci_latched_o),
  .ctrl_rd      (ctrl_rd)
);

// File: tb/test_hwmon_ctrl_reg.sv
`timescale 1ns/1ps
module test_hwmon_ctrl_reg;
  localparam int unsigned TB_CLK_HZ = 100_000;
  localparam int          EXP_LEN   = 1000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rd_data_o;
  logic [15:0] evt_i = '0;
  logic        ci_i = 1'b0;
  logic        mon_run_o, int_oe_o, int_do_o, rst_os_n_o, gpo_o, ci_latched_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk_i = ~clk_i;

  hwmon_ctrl_reg #(.CLK_HZ(TB_CLK_HZ), .PULSE_MS(10)) i_hwmon_ctrl_reg (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rd_data_o,
    .evt_i, .ci_i, .mon_run_o, .int_oe_o, .int_do_o,
    .rst_os_n_o, .gpo_o, .ci_latched_o
  );

  typedef struct {
    logic [2:0] a;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sbq[$];

  // monitor: pops expected read items and compares
  initial begin
    forever begin
      item_t it;
      wait (sbq.size() != 0);
      #1;
      it = sbq[0];
      n_tests++;
      if (rd_data_o !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr %0d: actual %h expected %h", it.tag, it.a, rd_data_o, it.exp);
      end
      void'(sbq.pop_front());
    end
  end

  task automatic rd_exp(input logic [2:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    addr_i = a;
    it.a = a; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    wait (sbq.size() == 0);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic evt_pulse(input logic [15:0] v);
    @(negedge clk_i); evt_i = v;
    @(negedge clk_i); evt_i = '0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(200_000 * 4);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    realtime t_fall;
    int len;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd_exp(3'd0, 8'h08, "R1 ctrl reset");
    rd_exp(3'd1, 8'h00, "R1 sts0 reset");
    rd_exp(3'd3, 8'h00, "R1 msk0 reset");
    rd_exp(3'd5, 8'h00, "R1 mode reset");
    chk("R6 int off at reset", int_oe_o, 1'b0);
    chk("R6 rst high at reset", rst_os_n_o, 1'b1);
    chk("R3 not running at reset", mon_run_o, 1'b0);

    // R3 start monitoring
    wr(3'd0, 8'h01);
    chk("R3 running", mon_run_o, 1'b1);
    evt_pulse(16'h0001);
    rd_exp(3'd1, 8'h01, "R2 status latched");
    chk("R2 int needs enable", int_oe_o, 1'b0);

    // R4 polarity
    wr(3'd0, 8'h03);
    chk("R4 int active", int_oe_o, 1'b1);
    chk("R4 active-low drive", int_do_o, 1'b0);
    wr(3'd0, 8'h07);
    chk("R4 active-high drive", int_do_o, 1'b1);

    // R2 mask
    wr(3'd3, 8'h01);
    chk("R2 masked", int_oe_o, 1'b0);
    wr(3'd3, 8'h00);
    chk("R2 unmasked", int_oe_o, 1'b1);

    // R5 stop keeps interrupt; R3 standby blocks latching
    wr(3'd0, 8'h06);
    chk("R5 int kept after stop", int_oe_o, 1'b1);
    chk("R3 standby", mon_run_o, 1'b0);
    evt_pulse(16'h0002);
    rd_exp(3'd1, 8'h01, "R3 no latch in standby");

    // R6 suppress
    wr(3'd0, 8'h0F);
    chk("R6 int suppressed", int_oe_o, 1'b0);
    chk("R6 monitoring stopped", mon_run_o, 1'b0);
    rd_exp(3'd1, 8'h01, "R6 status kept");
    wr(3'd0, 8'h07);
    chk("R6 int restored", int_oe_o, 1'b1);

    // R2 write-one-clear
    wr(3'd1, 8'h01);
    rd_exp(3'd1, 8'h00, "R2 status cleared");
    chk("R2 int off after clear", int_oe_o, 1'b0);

    // R9 general output
    wr(3'd0, 8'h47);
    chk("R9 gpo high", gpo_o, 1'b1);
    rd_exp(3'd0, 8'h47, "R9 ctrl readback");

    // R7 wrong mode ignored
    wr(3'd0, 8'h57);
    chk("R7 no pulse in wrong mode", rst_os_n_o, 1'b1);
    rd_exp(3'd0, 8'h47, "R7 request bit not held");

    // R7 pulse length, R8 retrigger ignored
    wr(3'd5, 8'h80);
    wr(3'd0, 8'h57);
    t_fall = $realtime;
    chk("R7 pulse started", rst_os_n_o, 1'b0);
    rd_exp(3'd0, 8'h57, "R7 request bit reads 1");
    repeat (200) @(negedge clk_i);
    wr(3'd0, 8'h57);
    for (int i = 0; i < 3000 && rst_os_n_o == 1'b0; i++) @(negedge clk_i);
    len = int'(($realtime - t_fall) / 4.0);
    n_tests++;
    if (len != EXP_LEN) begin
      n_fail++;
      $display("FAIL R7 R8 pulse length: actual %0d expected %0d", len, EXP_LEN);
    end
    rd_exp(3'd0, 8'h47, "R7 request bit self-cleared");

    // R6 suppress during pulse
    wr(3'd0, 8'h57);
    wr(3'd0, 8'h4F);
    chk("R6 rst forced high", rst_os_n_o, 1'b1);
    rd_exp(3'd0, 8'h5F, "R6 pulse still running");
    wr(3'd0, 8'h47);
    chk("R6 rst low again", rst_os_n_o, 1'b0);
    for (int i = 0; i < 2000 && rst_os_n_o == 1'b0; i++) @(negedge clk_i);
    rd_exp(3'd0, 8'h47, "R7 pulse ended");

    // R10 intrusion clear
    @(negedge clk_i); ci_i = 1'b1;
    @(negedge clk_i); ci_i = 1'b0;
    chk("R10 latch set", ci_latched_o, 1'b1);
    wr(3'd0, 8'h67);
    rd_exp(3'd0, 8'h67, "R10 clear bit reads 1");
    chk("R10 latch still set", ci_latched_o, 1'b1);
    @(negedge clk_i);
    rd_exp(3'd0, 8'h47, "R10 clear bit self-cleared");
    chk("R10 latch cleared", ci_latched_o, 1'b0);

    // R11 initialise with priority
    wr(3'd6, 8'h33);
    wr(3'd4, 8'h5A);
    evt_pulse(16'h0001);
    @(negedge clk_i); ci_i = 1'b1;
    @(negedge clk_i); ci_i = 1'b0;
    wr(3'd0, 8'h97);
    rd_exp(3'd0, 8'hC7, "R11 init bit shown, others ignored");
    chk("R11 no pulse from same write", rst_os_n_o, 1'b1);
    @(negedge clk_i);
    rd_exp(3'd0, 8'h08, "R11 ctrl default");
    rd_exp(3'd1, 8'h00, "R11 status default");
    rd_exp(3'd4, 8'h00, "R11 mask default");
    rd_exp(3'd5, 8'h00, "R11 mode default");
    rd_exp(3'd6, 8'h00, "R11 sensor cfg default");
    chk("R11 gpo default", gpo_o, 1'b0);
    chk("R11 latch untouched", ci_latched_o, 1'b1);

    done = 1'b1;
    finish_run();
  end
endmodule